// File: doc/BRIEF.md
# Serial Wire Debug Transaction Engine

This block carries out one register access, read or write, to either the debug port or an access port of a target over a two-wire Serial Wire Debug link. A controller loads the port select, direction, 2-bit register address and write data, then pulses `start_i`. The engine builds the 8-bit request with its parity, shifts it out, reads the 3-bit acknowledge and then moves the data phase with its parity bit. It drives the serial clock and the bidirectional data line itself, through a separate output and output enable.

A WAIT acknowledge makes the engine send the same request again, up to a number of extra attempts set by `retry_limit_i`. The access then ends with a timeout status. FAULT, an unknown acknowledge and a read parity mismatch each end the access with their own status code and zero read data. While an external sticky-fault flag is set, access-port requests are refused at once, without clocking the link. Debug-port requests still run.

One serial bit lasts two system clocks: the serial clock is low in the first and high in the second.

Top module: `swd_xact_engine`

## Requirements
- R1: The request byte, sent first, is bit0=1 (start), bit1=port select (1 = access port), bit2=direction (1 = read), bit3=addr[0], bit4=addr[1], bit5=even parity of bits 1..4, bit6=0, bit7=1. For example, a debug-port read of address 0 is 8'hA5.
- R2: Every serial field goes out least significant bit first, one bit per two `clk` cycles. `swclk_o` is low in the first cycle and high in the second. The engine changes `swdio_o` only when `swclk_o` falls, and samples `swdio_i` at the `clk` edge that ends the high half.
- R3: After the request comes one turnaround bit with `swdio_oe_o` low. Then three acknowledge bits are read, first bit in bit 0: OK=3'b001, WAIT=3'b010, FAULT=3'b100.
- R4: After WAIT and one turnaround bit, the identical request is sent again. If the access has already made `retry_limit_i` repeats, a further WAIT ends it instead with status 2 (timeout).
- R5: FAULT ends the access after one turnaround bit, with status 1 and `rdata_o` = 0.
- R6: Any acknowledge other than OK, WAIT or FAULT ends the access after one turnaround bit, with status 3 and `rdata_o` = 0.
- R7: A read with OK takes 32 data bits and a parity bit, then one turnaround bit. It ends with status 0 and the data if the parity is even over all 33 bits. On a mismatch it ends with status 4 and `rdata_o` = 0.
- R8: A write with OK has one turnaround bit, then 32 driven data bits and their even parity bit. Eight more clocked bits follow with `swdio_o` low and driven. It ends with status 0.
- R9: A start with port select = 1 while `sticky_fault_i` = 1 produces `done_o` in the next cycle with status 1 and `rdata_o` = 0, and `swclk_o` never rises. A debug-port access is not affected by the flag.
- R10: `busy_o` is high from the cycle after an accepted start until the last bit ends. `done_o` is a one-cycle pulse in the cycle after that, with `busy_o` low. A start while busy is ignored.
- R11: While not busy, `swclk_o` and `swdio_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an access (one-cycle pulse) |
| ap_sel_i | input | 1 | 1 = access port, 0 = debug port |
| read_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 2 | Register address bits [3:2] |
| wdata_i | input | 32 | Write data |
| retry_limit_i | input | 8 | Repeats allowed after WAIT |
| sticky_fault_i | input | 1 | Refuse access-port requests while high |
| rdata_o | output | 32 | Read data, valid with done |
| status_o | output | 3 | 0 ok, 1 fault, 2 timeout, 3 bad ack, 4 parity |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Access finished (pulse) |
| swclk_o | output | 1 | Serial clock |
| swdio_o | output | 1 | Serial data out |
| swdio_oe_o | output | 1 | Serial data output enable |
| swdio_i | input | 1 | Serial data in |

## Verification
The bench plays the target and steps on each rising edge of `swclk_o`. There it reads the host's bit and presents its own. The engine samples that bit one `clk` later, at the end of the high half. `done_o`, `status_o` and `rdata_o` are due one `clk` edge after the rising edge of the last serial bit, so the bench waits exactly that edge and checks one time unit later. A refused access-port start is due one cycle after the start edge and is checked at the following falling clock edge, together with a still-low `swclk_o`.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int DATA_W    = 32;
  localparam int REQ_W     = 8;
  localparam int IDLE_BITS = 8;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_FAULT   = 3'd1,
    ST_TIMEOUT = 3'd2,
    ST_BADACK  = 3'd3,
    ST_PARITY  = 3'd4
  } swd_status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_TRN_REQ, S_ACK, S_TRN_ACK,
    S_WDATA, S_WIDLE, S_RDATA, S_TRN_RD
  } swd_state_e;

  typedef enum logic [1:0] {
    NX_WRITE, NX_RETRY, NX_END
  } swd_next_e;
endpackage

// File: rtl/swd_bit_timer.sv
module swd_bit_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic swclk_o,
  output logic tick_o
);
  logic phase_q, phase_d;

  always_comb begin
    phase_d = 1'b0;
    if (run_i) phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign swclk_o = phase_q;
  assign tick_o  = run_i & phase_q;
endmodule

// File: rtl/swd_req_enc.sv
module swd_req_enc #(
  parameter int REQ_W = 8
) (
  input  logic             ap_sel_i,
  input  logic             read_i,
  input  logic [1:0]       addr_i,
  output logic [REQ_W-1:0] req_o
);
  logic par;
  assign par = ap_sel_i ^ read_i ^ addr_i[0] ^ addr_i[1];

  always_comb begin
    req_o      = '0;
    req_o[0]   = 1'b1;
    req_o[1]   = ap_sel_i;
    req_o[2]   = read_i;
    req_o[4:3] = addr_i;
    req_o[5]   = par;
    req_o[6]   = 1'b0;
    req_o[7]   = 1'b1;
  end
endmodule

// File: rtl/swd_xact_engine.sv
module swd_xact_engine
  import swd_pkg::*;
#(
  parameter int RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               ap_sel_i,
  input  logic               read_i,
  input  logic [1:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [RETRY_W-1:0] retry_limit_i,
  input  logic               sticky_fault_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [2:0]         status_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               swclk_o,
  output logic               swdio_o,
  output logic               swdio_oe_o,
  input  logic               swdio_i
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_REQ  = CNT_W'(REQ_W - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_IDLE = CNT_W'(IDLE_BITS - 1);

  swd_state_e           state_q, state_d;
  swd_next_e            nx_q, nx_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [REQ_W-1:0]     req_q, req_d, rsh_req_q, rsh_req_d;
  logic [DATA_W:0]      wsh_q, wsh_d;
  logic [DATA_W-1:0]    rsh_q, rsh_d, rdata_q, rdata_d;
  logic [1:0]           ack_q, ack_d;
  logic [RETRY_W-1:0]   wcnt_q, wcnt_d;
  logic                 rd_q, rd_d, done_q, done_d;
  logic [2:0]           status_q, status_d;
  logic [REQ_W-1:0]     req_enc;
  logic [2:0]           ack_full;
  logic                 tick, run;

  assign run = (state_q != S_IDLE);

  swd_bit_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .swclk_o (swclk_o),
    .tick_o  (tick)
  );

  swd_req_enc #(.REQ_W(REQ_W)) u_enc (
    .ap_sel_i (ap_sel_i),
    .read_i   (read_i),
    .addr_i   (addr_i),
    .req_o    (req_enc)
  );

  assign ack_full = {swdio_i, ack_q};

  always_comb begin
    state_d   = state_q;
    nx_d      = nx_q;
    cnt_d     = cnt_q;
    req_d     = req_q;
    rsh_req_d = rsh_req_q;
    wsh_d     = wsh_q;
    rsh_d     = rsh_q;
    rdata_d   = rdata_q;
    ack_d     = ack_q;
    wcnt_d    = wcnt_q;
    rd_d      = rd_q;
    status_d  = status_q;
    done_d    = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        if (ap_sel_i && sticky_fault_i) begin
          done_d   = 1'b1;
          status_d = ST_FAULT;
          rdata_d  = '0;
        end else begin
          state_d   = S_REQ;
          req_d     = req_enc;
          rsh_req_d = req_enc;
          cnt_d     = '0;
          rd_d      = read_i;
          wsh_d     = {^wdata_i, wdata_i};
          wcnt_d    = '0;
        end
      end
      S_REQ: if (tick) begin
        rsh_req_d = rsh_req_q >> 1;
        cnt_d     = cnt_q + 1'b1;
        if (cnt_q == LAST_REQ) begin
          state_d = S_TRN_REQ;
          cnt_d   = '0;
        end
      end
      S_TRN_REQ: if (tick) state_d = S_ACK;
      S_ACK: if (tick) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q != CNT_W'(2)) begin
          ack_d[cnt_q[0]] = swdio_i;
        end else begin
          cnt_d   = '0;
          state_d = S_TRN_ACK;
          nx_d    = NX_END;
          if (ack_full == ACK_OK) begin
            status_d = ST_OK;
            if (rd_q) state_d = S_RDATA;
            else      nx_d    = NX_WRITE;
          end else if (ack_full == ACK_WAIT) begin
            if (wcnt_q == retry_limit_i) begin
              status_d = ST_TIMEOUT;
            end else begin
              wcnt_d = wcnt_q + 1'b1;
              nx_d   = NX_RETRY;
            end
          end else if (ack_full == ACK_FAULT) begin
            status_d = ST_FAULT;
          end else begin
            status_d = ST_BADACK;
          end
        end
      end
      S_TRN_ACK: if (tick) begin
        cnt_d = '0;
        unique case (nx_q)
          NX_WRITE: state_d = S_WDATA;
          NX_RETRY: begin
            state_d   = S_REQ;
            rsh_req_d = req_q;
          end
          default: begin
            state_d = S_IDLE;
            done_d  = 1'b1;
            rdata_d = '0;
          end
        endcase
      end
      S_WDATA: if (tick) begin
        wsh_d = wsh_q >> 1;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_DATA) begin
          state_d = S_WIDLE;
          cnt_d   = '0;
        end
      end
      S_WIDLE: if (tick) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_IDLE) begin
          state_d  = S_IDLE;
          done_d   = 1'b1;
          status_d = ST_OK;
          rdata_d  = '0;
        end
      end
      S_RDATA: if (tick) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q != LAST_DATA) begin
          rsh_d = {swdio_i, rsh_q[DATA_W-1:1]};
        end else begin
          state_d  = S_TRN_RD;
          status_d = ((^rsh_q) ^ swdio_i) ? ST_PARITY : ST_OK;
        end
      end
      S_TRN_RD: if (tick) begin
        state_d = S_IDLE;
        done_d  = 1'b1;
        rdata_d = (status_q == ST_OK) ? rsh_q : '0;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      nx_q      <= NX_END;
      cnt_q     <= '0;
      req_q     <= '0;
      rsh_req_q <= '0;
      wsh_q     <= '0;
      rsh_q     <= '0;
      rdata_q   <= '0;
      ack_q     <= '0;
      wcnt_q    <= '0;
      rd_q      <= 1'b0;
      status_q  <= ST_OK;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      nx_q      <= nx_d;
      cnt_q     <= cnt_d;
      req_q     <= req_d;
      rsh_req_q <= rsh_req_d;
      wsh_q     <= wsh_d;
      rsh_q     <= rsh_d;
      rdata_q   <= rdata_d;
      ack_q     <= ack_d;
      wcnt_q    <= wcnt_d;
      rd_q      <= rd_d;
      status_q  <= status_d;
      done_q    <= done_d;
    end
  end

  always_comb begin
    swdio_oe_o = 1'b0;
    swdio_o    = 1'b0;
    unique case (state_q)
      S_REQ: begin
        swdio_oe_o = 1'b1;
        swdio_o    = rsh_req_q[0];
      end
      S_WDATA: begin
        swdio_oe_o = 1'b1;
        swdio_o    = wsh_q[0];
      end
      S_WIDLE: swdio_oe_o = 1'b1;
      default: ;
    endcase
  end

  assign busy_o   = run;
  assign done_o   = done_q;
  assign status_o = status_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/swd_xact_chk.sv
module swd_xact_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        ap_sel_i,
  input logic        sticky_fault_i,
  input logic [31:0] rdata_o,
  input logic [2:0]  status_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        swclk_o,
  input logic        swdio_o,
  input logic        swdio_oe_o
);
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!swclk_o && !swdio_oe_o)); // R11
  AST_CLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (swclk_o != $past(swclk_o))); // R2
  AST_OUT_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && swclk_o) |-> ($stable(swdio_o) && $stable(swdio_oe_o))); // R2
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o != 3'd0) |-> (rdata_o == 32'd0)); // R5
  AST_STICKY_AP: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && ap_sel_i && sticky_fault_i)
      |=> (done_o && status_o == 3'd1 && !swclk_o)); // R9
endmodule

bind swd_xact_engine swd_xact_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .ap_sel_i       (ap_sel_i),
  .sticky_fault_i (sticky_fault_i),
  .rdata_o        (rdata_o),
  .status_o       (status_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .swclk_o        (swclk_o),
  .swdio_o        (swdio_o),
  .swdio_oe_o     (swdio_oe_o)
);

// File: tb/swd_xact_engine_tb.sv
`timescale 1ns/1ps
module swd_xact_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, ap_sel_i = 1'b0, read_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [7:0]  retry_limit_i = 8'd0;
  logic        sticky_fault_i = 1'b0;
  logic [31:0] rdata_o;
  logic [2:0]  status_o;
  logic        busy_o, done_o, swclk_o, swdio_o, swdio_oe_o;
  logic        swdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  swd_xact_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ap_sel_i(ap_sel_i),
    .read_i(read_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .retry_limit_i(retry_limit_i), .sticky_fault_i(sticky_fault_i),
    .rdata_o(rdata_o), .status_o(status_o), .busy_o(busy_o), .done_o(done_o),
    .swclk_o(swclk_o), .swdio_o(swdio_o), .swdio_oe_o(swdio_oe_o),
    .swdio_i(swdio_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] req_of(input logic ap, input logic rd,
                                        input logic [1:0] a);
    return {1'b1, 1'b0, ap ^ rd ^ a[0] ^ a[1], a[1], a[0], rd, ap, 1'b1};
  endfunction

  task automatic kick(input logic ap, input logic rd, input logic [1:0] a,
                      input logic [31:0] wd);
    @(negedge clk);
    ap_sel_i = ap; read_i = rd; addr_i = a; wdata_i = wd; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // one request + turnaround + ack; checks the request byte (R1, R3)
  task automatic attempt(input logic [7:0] exp_req, input logic [2:0] ack,
                         input string tag);
    logic [7:0] got;
    bit oe_ok;
    oe_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(posedge swclk_o);
      got[i] = swdio_o;
      if (!swdio_oe_o) oe_ok = 1'b0;
    end
    chk(got == exp_req && oe_ok, {tag, " R1 request"}, {24'd0, got}, {24'd0, exp_req});
    @(posedge swclk_o);
    chk(swdio_oe_o == 1'b0, {tag, " R3 turnaround"}, {31'd0, swdio_oe_o}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(posedge swclk_o);
      swdio_i = ack[i];
    end
  endtask

  task automatic trn(input string tag);
    @(posedge swclk_o);
    swdio_i = 1'b1;
    chk(swdio_oe_o == 1'b0, {tag, " turnaround"}, {31'd0, swdio_oe_o}, 32'd0);
  endtask

  task automatic give_read(input logic [31:0] d, input logic par);
    for (int i = 0; i < 33; i++) begin
      @(posedge swclk_o);
      swdio_i = (i < 32) ? d[i] : par;
    end
    trn("R7 read");
  endtask

  task automatic take_write(input logic [31:0] d, input string tag);
    logic [32:0] got;
    bit idle_ok;
    idle_ok = 1'b1;
    trn({tag, " R8 pre-data"});
    for (int i = 0; i < 33; i++) begin
      @(posedge swclk_o);
      got[i] = swdio_o;
    end
    chk(got[31:0] == d, {tag, " R8 data"}, got[31:0], d);
    chk(got[32] == ^d, {tag, " R8 parity"}, {31'd0, got[32]}, {31'd0, ^d});
    for (int i = 0; i < 8; i++) begin
      @(posedge swclk_o);
      if (swdio_o !== 1'b0 || swdio_oe_o !== 1'b1) idle_ok = 1'b0;
    end
    chk(idle_ok, {tag, " R8 idle bits"}, {31'd0, idle_ok}, 32'd1);
  endtask

  // result due one clk edge after the last serial rising edge (R10)
  task automatic finish(input logic [2:0] st, input logic [31:0] rd,
                        input string tag);
    @(posedge clk);
    #1;
    chk(done_o === 1'b1 && busy_o === 1'b0, {tag, " R10 done"},
        {30'd0, done_o, busy_o}, 32'd2);
    chk(status_o === st, {tag, " status"}, {29'd0, status_o}, {29'd0, st});
    chk(rdata_o === rd, {tag, " rdata"}, rdata_o, rd);
    @(posedge clk);
    #1;
    chk(done_o === 1'b0, {tag, " R10 done pulse"}, {31'd0, done_o}, 32'd0);
  endtask

  task automatic t_reset;
    chk(!swclk_o && !swdio_oe_o && !busy_o && !done_o, "R11 reset idle",
        {28'd0, swclk_o, swdio_oe_o, busy_o, done_o}, 32'd0);
  endtask

  task automatic t_dp_read;
    kick(1'b0, 1'b1, 2'b00, 32'd0);
    chk(busy_o === 1'b1, "R10 busy", {31'd0, busy_o}, 32'd1);
    chk(req_of(1'b0, 1'b1, 2'b00) == 8'hA5, "R1 example", 32'hA5, 32'hA5);
    attempt(req_of(1'b0, 1'b1, 2'b00), 3'b001, "dp read");
    give_read(32'h2BA0_1477, ^32'h2BA0_1477);
    finish(3'd0, 32'h2BA0_1477, "R7 dp read");
    chk(!swclk_o && !swdio_oe_o, "R11 idle after", {30'd0, swclk_o, swdio_oe_o}, 32'd0);
  endtask

  task automatic t_ap_write;
    kick(1'b1, 1'b0, 2'b01, 32'hDEAD_BEEF);
    attempt(req_of(1'b1, 1'b0, 2'b01), 3'b001, "ap write");
    take_write(32'hDEAD_BEEF, "ap write");
    finish(3'd0, 32'd0, "R8 ap write");
  endtask

  task automatic t_wait_then_ok;
    retry_limit_i = 8'd3;
    kick(1'b1, 1'b1, 2'b11, 32'd0);
    attempt(req_of(1'b1, 1'b1, 2'b11), 3'b010, "R4 wait1");
    trn("R4 wait1");
    attempt(req_of(1'b1, 1'b1, 2'b11), 3'b010, "R4 wait2");
    trn("R4 wait2");
    attempt(req_of(1'b1, 1'b1, 2'b11), 3'b001, "R4 retry ok");
    give_read(32'h0000_0001, 1'b1);
    finish(3'd0, 32'h0000_0001, "R4 retry read");
  endtask

  task automatic t_timeout;
    retry_limit_i = 8'd1;
    kick(1'b0, 1'b1, 2'b10, 32'd0);
    attempt(req_of(1'b0, 1'b1, 2'b10), 3'b010, "R4 to1");
    trn("R4 to1");
    attempt(req_of(1'b0, 1'b1, 2'b10), 3'b010, "R4 to2");
    trn("R4 to2");
    finish(3'd2, 32'd0, "R4 timeout");
  endtask

  task automatic t_fault;
    kick(1'b1, 1'b1, 2'b00, 32'd0);
    attempt(req_of(1'b1, 1'b1, 2'b00), 3'b100, "R5 fault");
    trn("R5 fault");
    finish(3'd1, 32'd0, "R5 fault");
  endtask

  task automatic t_badack;
    kick(1'b0, 1'b0, 2'b01, 32'h1234_5678);
    attempt(req_of(1'b0, 1'b0, 2'b01), 3'b111, "R6 badack");
    trn("R6 badack");
    finish(3'd3, 32'd0, "R6 badack");
  endtask

  task automatic t_parity;
    kick(1'b0, 1'b1, 2'b01, 32'd0);
    attempt(req_of(1'b0, 1'b1, 2'b01), 3'b001, "R7 parity");
    give_read(32'h8000_0003, ~(^32'h8000_0003));
    finish(3'd4, 32'd0, "R7 parity error");
  endtask

  task automatic t_sticky;
    sticky_fault_i = 1'b1;
    kick(1'b1, 1'b1, 2'b10, 32'd0);
    chk(done_o === 1'b1 && status_o === 3'd1 && rdata_o === 32'd0,
        "R9 sticky ap refused", {28'd0, done_o, status_o}, 32'h9);
    chk(swclk_o === 1'b0 && busy_o === 1'b0, "R9 no clock",
        {30'd0, swclk_o, busy_o}, 32'd0);
    @(negedge clk);
    chk(done_o === 1'b0, "R9 done pulse", {31'd0, done_o}, 32'd0);
    kick(1'b0, 1'b1, 2'b00, 32'd0);
    attempt(req_of(1'b0, 1'b1, 2'b00), 3'b001, "R9 dp runs");
    give_read(32'hCAFE_F00D, ^32'hCAFE_F00D);
    finish(3'd0, 32'hCAFE_F00D, "R9 dp read");
    sticky_fault_i = 1'b0;
  endtask

  task automatic t_start_busy;
    kick(1'b0, 1'b1, 2'b11, 32'd0);
    fork
      begin
        ap_sel_i = 1'b1; read_i = 1'b0; addr_i = 2'b00; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end
      attempt(req_of(1'b0, 1'b1, 2'b11), 3'b001, "R10 busy start");
    join
    give_read(32'h5555_AAAA, ^32'h5555_AAAA);
    finish(3'd0, 32'h5555_AAAA, "R10 ignored start");
    repeat (4) @(posedge clk);
    #1;
    chk(busy_o === 1'b0 && swclk_o === 1'b0, "R10 no late start",
        {30'd0, busy_o, swclk_o}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_dp_read();
    t_ap_write();
    t_wait_then_ok();
    t_timeout();
    t_fault();
    t_badack();
    t_parity();
    t_sticky();
    t_start_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule